// File: doc/BRIEF.md
# Length-Steered Serial Configuration Port

This block is the slave side of a three-wire serial write port that loads three configuration registers: an 8-bit control word, a 16-bit divider word and a 24-bit counter word. The stream carries no address or steering bits. The port counts how many serial clock rising edges occur while the active-low enable is asserted. When the enable is released, that count chooses the register that takes the word. Because every bit is payload, a host reaches any register in any order by sending exactly as many bits as that register is wide.

The divider word is split into two parts. Its three upper bits are committed directly. Its thirteen lower bits go first into a holding buffer. That buffer is copied into the visible divider output either by the next counter-word write or by an enable pulse with no clock edges. This lets the divider and counter values change together. The block also drives a serial data-out bit that follows the top of the shift register and moves only on serial clock falling edges.

The enable, serial clock and data pins are asynchronous to the system clock. Each passes through a two-stage synchronizer, and serial clock edges are found from the synchronized samples. The serial pins carry no valid/ready handshake, because the host owns the timing. The serial clock must be slow enough that every high and low phase lasts at least two system clock periods.

Top module: `cfg_serial_port`

## Requirements
- R1: While the synchronized enable is low, each rising edge of the serial clock shifts the data bit into the least significant end of the shift register, so the first bit sent ends up most significant. The bit count saturates at 33.
- R2: Releasing the enable after exactly 8 bits loads those 8 bits into `ctrl_q`.
- R3: Releasing the enable after exactly 16 bits loads bits 15..13 into `div_q[15:13]` at once. It loads bits 12..0 into the holding buffer only, and `div_q[12:0]` does not change.
- R4: Releasing the enable after exactly 24 bits loads `cnt_q`. In the same cycle it copies the holding buffer, as it stood before that transfer, into `div_q[12:0]`.
- R5: An enable low pulse with no serial clock rising edge copies the holding buffer into `div_q[12:0]` and leaves every other output unchanged.
- R6: Releasing the enable after any other count (1 to 7, 9 to 15, 17 to 23, 25 or more) changes no output and leaves the holding buffer unchanged.
- R7: Register outputs change only in the system cycle that follows the detected rising edge of the enable. They stay constant while bits are being shifted.
- R8: While the enable is high, serial clock edges are ignored and the bit count and shift register are held at zero.
- R9: `sdo` takes the most significant shift register bit on each serial clock falling edge, and changes at no other time.
- R10: An active-low reset clears `ctrl_q`, `div_q`, `cnt_q`, the holding buffer and `sdo` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Serial enable, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| sdo | output | 1 | Serial data out, updated on serial clock falling edges |
| ctrl_q | output | 8 | Control register |
| div_q | output | 16 | Divider register: upper 3 bits direct, lower 13 bits from the second buffer |
| cnt_q | output | 24 | Counter register |

## Verification
The bench builds the block with its default widths: 8, 16 and 24 bits, a 13-bit buffered field, and a count ceiling of 32. At these sizes every possible transfer length, from zero through 34 bits, can be swept in one run, and the sweep crosses the saturation point of the bit counter. Each length carries a distinct arithmetically derived word, so each commit is checked against a reference model. The model shows whether the holding buffer was promoted or left alone. For streams of 25 bits or more, the bench also follows `sdo` bit by bit after each falling edge, together with ignored clocks while the enable is high.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_DIV,
    TGT_CNT,
    TGT_PROMOTE
  } tgt_e;

  // Maps a transfer length onto the register it addresses.
  function automatic tgt_e len_to_target(input int unsigned nbits,
                                         input int unsigned ctrl_len,
                                         input int unsigned div_len,
                                         input int unsigned cnt_len);
    tgt_e t;
    if (nbits == 0)             t = TGT_PROMOTE;
    else if (nbits == ctrl_len) t = TGT_CTRL;
    else if (nbits == div_len)  t = TGT_DIV;
    else if (nbits == cnt_len)  t = TGT_CNT;
    else                        t = TGT_NONE;
    return t;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int SH_W     = 24,
  parameter int MAX_BITS = 32,
  localparam int CW      = $clog2(MAX_BITS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_n_s,
  input  logic            sck_s,
  input  logic            sdi_s,
  output logic [SH_W-1:0] shreg,
  output logic [CW-1:0]   bit_cnt,
  output logic            commit,
  output logic            sck_fall,
  output logic            sdo
);

  localparam logic [CW-1:0] SAT = CW'(MAX_BITS + 1);

  logic sck_q, en_n_q, sck_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign commit   = en_n_s & ~en_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      en_n_q  <= 1'b1;
      shreg   <= '0;
      bit_cnt <= '0;
      sdo     <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      en_n_q <= en_n_s;
      if (en_n_s) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[SH_W-2:0], sdi_s};
        if (bit_cnt != SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sck_fall) sdo <= shreg[SH_W-1];
    end
  end

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_port_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 16,
  parameter int DB_W   = 13,
  parameter int CNT_W  = 24,
  parameter int CW     = 6,
  localparam int TOP_W = DIV_W - DB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [CW-1:0]    bit_cnt,
  input  logic [CNT_W-1:0] shreg,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DB_W-1:0]   hold_buf
);

  logic [TOP_W-1:0] div_top;
  logic [DB_W-1:0]  div_act;
  tgt_e             tgt;

  always_comb begin
    tgt = TGT_NONE;
    if (commit)
      tgt = len_to_target(32'(bit_cnt), CTRL_W, DIV_W, CNT_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_top  <= '0;
      div_act  <= '0;
      hold_buf <= '0;
      cnt_q    <= '0;
    end else begin
      case (tgt)
        TGT_CTRL: ctrl_q <= shreg[CTRL_W-1:0];
        TGT_DIV: begin
          div_top  <= shreg[DIV_W-1:DB_W];
          hold_buf <= shreg[DB_W-1:0];
        end
        TGT_CNT: begin
          cnt_q   <= shreg;
          div_act <= hold_buf;
        end
        TGT_PROMOTE: div_act <= hold_buf;
        default: ;
      endcase
    end
  end

  assign div_q = {div_top, div_act};

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int CTRL_W   = 8,
  parameter int DIV_W    = 16,
  parameter int DB_W     = 13,
  parameter int CNT_W    = 24,
  parameter int MAX_BITS = 32,
  parameter int SYNC_N   = 2,
  localparam int CW      = $clog2(MAX_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  cnt_q
);

  logic [2:0]       pins_s;
  logic             en_n_s, sck_s, sdi_s;
  logic [CNT_W-1:0] shreg;
  logic [CW-1:0]    bit_cnt;
  logic             commit, sck_fall;
  logic [DB_W-1:0]  hold_buf;

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({sen_n, sck, sdi}), .d_sync(pins_s)
  );

  assign {en_n_s, sck_s, sdi_s} = pins_s;

  cfg_shift #(.SH_W(CNT_W), .MAX_BITS(MAX_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_n_s(en_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .shreg(shreg), .bit_cnt(bit_cnt), .commit(commit),
    .sck_fall(sck_fall), .sdo(sdo)
  );

  cfg_regs #(.CTRL_W(CTRL_W), .DIV_W(DIV_W), .DB_W(DB_W),
             .CNT_W(CNT_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .bit_cnt(bit_cnt), .shreg(shreg),
    .ctrl_q(ctrl_q), .div_q(div_q), .cnt_q(cnt_q), .hold_buf(hold_buf)
  );

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int CTRL_W   = 8,
  parameter int DIV_W    = 16,
  parameter int DB_W     = 13,
  parameter int CNT_W    = 24,
  parameter int MAX_BITS = 32,
  parameter int CW       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              sck_fall,
  input logic              en_n_s,
  input logic [CW-1:0]     bit_cnt,
  input logic [DB_W-1:0]   hold_buf,
  input logic              sdo,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DIV_W-1:0]  div_q,
  input logic [CNT_W-1:0]  cnt_q
);

  logic legal_len;
  assign legal_len = (bit_cnt == CW'(0)) || (bit_cnt == CW'(CTRL_W)) ||
                     (bit_cnt == CW'(DIV_W)) || (bit_cnt == CW'(CNT_W));

  p_cnt_ceiling_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(MAX_BITS + 1));

  p_only_at_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl_q) && $stable(div_q) && $stable(cnt_q));

  p_illegal_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !legal_len |=> $stable(ctrl_q) && $stable(div_q) &&
                             $stable(cnt_q) && $stable(hold_buf));

  p_ctrl_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && bit_cnt == CW'(CTRL_W) |=> $stable(div_q) && $stable(cnt_q));

  p_div_low_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && bit_cnt == CW'(DIV_W) |=> $stable(div_q[DB_W-1:0]) && $stable(cnt_q));

  p_promote_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && bit_cnt == CW'(CNT_W) |=>
      div_q[DB_W-1:0] == $past(hold_buf) && $stable(div_q[DIV_W-1:DB_W]));

  p_promote_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && bit_cnt == CW'(0) |=>
      div_q[DB_W-1:0] == $past(hold_buf) && $stable(cnt_q) && $stable(ctrl_q));

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> bit_cnt == '0);

  p_sdo_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sdo));

endmodule

bind cfg_serial_port cfg_port_chk #(
  .CTRL_W(CTRL_W), .DIV_W(DIV_W), .DB_W(DB_W), .CNT_W(CNT_W),
  .MAX_BITS(MAX_BITS), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .commit(commit), .sck_fall(sck_fall),
  .en_n_s(en_n_s), .bit_cnt(bit_cnt), .hold_buf(hold_buf), .sdo(sdo),
  .ctrl_q(ctrl_q), .div_q(div_q), .cnt_q(cnt_q)
);

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [7:0]  ctrl_q;
  logic [15:0] div_q;
  logic [23:0] cnt_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0]  m_ctrl = '0;
  logic [2:0]  m_top  = '0;
  logic [12:0] m_buf1 = '0, m_buf2 = '0;
  logic [23:0] m_cnt  = '0;

  always #2 clk = ~clk;

  cfg_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .ctrl_q(ctrl_q), .div_q(div_q), .cnt_q(cnt_q)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_regs(input string req);
    chk({req, " ctrl"}, 40'(ctrl_q), 40'(m_ctrl));
    chk({req, " div"},  40'(div_q),  40'({m_top, m_buf2}));
    chk({req, " cnt"},  40'(cnt_q),  40'(m_cnt));
  endtask

  // Sends n bits, first bit d[n-1]; optionally follows sdo (R9).
  task automatic xfer(input int n, input logic [39:0] d, input bit follow_sdo);
    logic [7:0] c0 = ctrl_q; logic [15:0] v0 = div_q; logic [23:0] k0 = cnt_q;
    logic exp_sdo;
    sen_n = 1'b0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      sdi = d[n-1-i];
      wclk(2);
      sck = 1'b1;
      wclk(4);
      if (follow_sdo && i == 23) begin
        chk("R9 sdo before fall", 40'(sdo), 40'(0));
      end
      sck = 1'b0;
      wclk(4);
      if (follow_sdo) begin
        exp_sdo = (i >= 23) ? d[n-1-(i-23)] : 1'b0;
        chk("R9 sdo after fall", 40'(sdo), 40'(exp_sdo));
      end
      if (i == n/2) chk("R7 stable while shifting",
                        40'({ctrl_q, div_q} ^ {c0, v0}) | 40'(cnt_q ^ k0), 40'(0));
    end
    sen_n = 1'b1;
    wclk(6);
    case (n)
      0:  m_buf2 = m_buf1;
      8:  m_ctrl = d[7:0];
      16: begin m_top = d[15:13]; m_buf1 = d[12:0]; end
      24: begin m_cnt = d[23:0]; m_buf2 = m_buf1; end
      default: ;
    endcase
  endtask

  function automatic string req_for(input int n);
    case (n)
      0: return "R5"; 8: return "R2"; 16: return "R3"; 24: return "R4";
      default: return "R6";
    endcase
  endfunction

  initial begin
    wclk(3);
    chk("R10 reset ctrl", 40'(ctrl_q), 40'(0));
    chk("R10 reset div",  40'(div_q),  40'(0));
    chk("R10 reset cnt",  40'(cnt_q),  40'(0));
    chk("R10 reset sdo",  40'(sdo),    40'(0));
    rst_n = 1'b1;
    wclk(4);

    // R8: clocks with enable high are ignored
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1; wclk(2); sck = 1'b1; wclk(4); sck = 1'b0; wclk(4);
    end
    xfer(8, 40'h5A, 1'b0);
    chk_regs("R8 idle clocks ignored");

    // R3 then R4: buffered low field moves with the counter word
    xfer(16, 40'hB7E3, 1'b0);
    chk_regs("R3 div write");
    xfer(24, 40'h12_3456, 1'b0);
    chk_regs("R4 counter promote");
    // R3 then R5: empty pulse promotes
    xfer(16, 40'h4C21, 1'b0);
    chk_regs("R3 div write 2");
    xfer(0, 40'h0, 1'b0);
    chk_regs("R5 empty pulse");

    // Sweep of every length 0..34 (R1 count ceiling crossed at 33, 34)
    for (int n = 0; n <= 34; n++) begin
      logic [39:0] d = 40'hA5_3C_96_E1_7B ^ (40'(n) * 40'h01_2F_4B_87_13);
      xfer(n, d, n >= 25);
      chk_regs({req_for(n), $sformatf(" R1 len %0d", n)});
    end

    // R1: MSB-first ordering visible in counter word
    xfer(24, 40'h80_0001, 1'b0);
    chk("R1 msb first", 40'(cnt_q), 40'h80_0001);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule